// File: doc/BRIEF.md
# Gated Frequency and Period Counter

This block measures a signal for a radio tuner controller, typically an intermediate frequency, to tell whether a station is present. It has two asynchronous event inputs. The fast input passes through a fixed divide-by-eight prescaler before it reaches the counter. The slow input is counted directly. A single enable bit does two jobs: while it is low, everything is held cleared, and raising it arms a new measurement. A timebase tick, supplied from outside, sets both the gate window and the period reference.

In frequency mode, the gate opens on the first tick after enable. It stays open for a short or a long number of ticks, and every selected event seen during the window increments the counter. In period mode, the counter uses the slow input only. It counts timebase ticks from one rising edge of that input to the next one, or to the second one after it. When a measurement ends, the block raises a done level and a one-cycle done event for the serial readout logic. The result then stays frozen until the enable bit drops. The counter saturates at its maximum value and does not wrap.

Top module: `gated_meas_counter`

## Requirements
- R1: While `run_en_i` is 0, `count_o`, `done_o` and `done_evt_o` read 0 one cycle later, and edges on `hf_i` or `lf_i` have no effect on them.
- R2: In frequency mode (`period_mode_i`=0) with `sel_low_i`=1, the final `count_o` equals the number of rising edges of `lf_i` seen while the gate is open.
- R3: In frequency mode with `sel_low_i`=0, the final `count_o` equals the number of rising edges of `hf_i` in the gate, divided by 8 and rounded down; the prescaler restarts from zero on every enable.
- R4: The gate opens on the first `tick_i` after enable and closes on the GATE_SHORT-th following tick (`gate_long_i`=0) or the GATE_LONG-th (`gate_long_i`=1); `done_o` rises the cycle after the closing tick and stays 0 before it.
- R5: In period mode (`period_mode_i`=1), `count_o` counts `tick_i` pulses from a first rising edge of `lf_i` until the next edge (`gate_long_i`=0) or the second following edge (`gate_long_i`=1); `sel_low_i` is ignored and `done_o` rises after the closing edge.
- R6: The count saturates at 2^CNT_W-1 and never wraps; while enabled it steps by at most one per cycle and never decreases.
- R7: Once `done_o` is 1, `count_o` and `done_o` hold while `run_en_i` stays 1, whatever the event inputs do.
- R8: `done_evt_o` is high for exactly one cycle, the first cycle in which `done_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| run_en_i | input | 1 | 0: hold cleared; 1: arm and measure |
| sel_low_i | input | 1 | Frequency mode source: 1 selects lf_i, 0 selects hf_i via divide-by-8 |
| period_mode_i | input | 1 | 0: frequency measurement, 1: period measurement on lf_i |
| gate_long_i | input | 1 | Selects the long gate or two periods |
| tick_i | input | 1 | Timebase tick, one clock wide |
| hf_i | input | 1 | Asynchronous fast event input |
| lf_i | input | 1 | Asynchronous slow event input |
| count_o | output | CNT_W | Measurement result |
| done_o | output | 1 | Measurement complete level |
| done_evt_o | output | 1 | One-cycle completion event |

## Verification
Some properties are checked by assertions on every cycle: the clear while disabled, the frozen result after completion, saturation, the monotonic single-step growth of the count, and the single-cycle shape of the done event. Other behaviours only show up in the bench's scenarios. These are the gate length counted in ticks, the divide-by-eight rounding, the number of ticks spanned by one or two input periods, and the inputs being ignored while disabled. A second, narrow instance shares the stimulus so that saturation is reached in a short run.

// File: rtl/gmc_pkg.sv
package gmc_pkg;
  typedef enum logic [1:0] {
    GS_ARM  = 2'd0,
    GS_OPEN = 2'd1,
    GS_DONE = 2'd2
  } gate_state_e;
endpackage

// File: rtl/gmc_edge_sync.sv
module gmc_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic async_i,
  output logic rise_o
);
  logic [2:0] pipe_q, pipe_d;

  always_comb begin
    if (clr_i) pipe_d = '0;
    else       pipe_d = {pipe_q[1:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  // pipe_q[1] is the second synchronizer stage, pipe_q[2] its delayed copy
  assign rise_o = pipe_q[1] & ~pipe_q[2];
endmodule

// File: rtl/gmc_prescaler.sv
module gmc_prescaler #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ev_i,
  output logic ev_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = ev_i && (cnt_q == PW'(DIV - 1));

  always_comb begin
    if (clr_i)     cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (ev_i) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign ev_o = wrap & ~clr_i;
endmodule

// File: rtl/gmc_gate_ctrl.sv
module gmc_gate_ctrl
  import gmc_pkg::*;
#(
  parameter int GATE_SHORT = 60,
  parameter int GATE_LONG  = 120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic period_mode_i,
  input  logic gate_long_i,
  input  logic tick_i,
  input  logic lf_rise_i,
  output logic open_o,
  output logic done_o,
  output logic done_evt_o
);
  localparam int TW = $clog2(GATE_LONG + 1);

  gate_state_e   state_q, state_d;
  logic [TW-1:0] step_cnt_q, step_cnt_d;
  logic [TW-1:0] limit;
  logic          step;
  logic          evt_q, evt_d;

  always_comb begin
    if (period_mode_i) limit = gate_long_i ? TW'(2) : TW'(1);
    else               limit = gate_long_i ? TW'(GATE_LONG) : TW'(GATE_SHORT);
  end

  assign step = period_mode_i ? lf_rise_i : tick_i;

  always_comb begin
    state_d    = state_q;
    step_cnt_d = step_cnt_q;
    evt_d      = 1'b0;
    if (clr_i) begin
      state_d    = GS_ARM;
      step_cnt_d = '0;
    end else begin
      unique case (state_q)
        GS_ARM: begin
          if (step) begin
            state_d    = GS_OPEN;
            step_cnt_d = '0;
          end
        end
        GS_OPEN: begin
          if (step) begin
            if (step_cnt_q == limit - 1'b1) begin
              state_d = GS_DONE;
              evt_d   = 1'b1;
            end else begin
              step_cnt_d = step_cnt_q + 1'b1;
            end
          end
        end
        GS_DONE: state_d = GS_DONE;
        default: state_d = GS_ARM;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= GS_ARM;
      step_cnt_q <= '0;
      evt_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      step_cnt_q <= step_cnt_d;
      evt_q      <= evt_d;
    end
  end

  assign open_o     = (state_q == GS_OPEN);
  assign done_o     = (state_q == GS_DONE);
  assign done_evt_o = evt_q;
endmodule

// File: rtl/gmc_sat_counter.sv
module gmc_sat_counter #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_max;

  assign at_max = &cnt_q;

  always_comb begin
    if (clr_i)                cnt_d = '0;
    else if (inc_i && !at_max) cnt_d = cnt_q + 1'b1;
    else                      cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/gated_meas_counter.sv
module gated_meas_counter #(
  parameter int CNT_W      = 20,
  parameter int HF_DIV     = 8,
  parameter int GATE_SHORT = 60,
  parameter int GATE_LONG  = 120
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_en_i,
  input  logic             sel_low_i,
  input  logic             period_mode_i,
  input  logic             gate_long_i,
  input  logic             tick_i,
  input  logic             hf_i,
  input  logic             lf_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o,
  output logic             done_evt_o
);
  localparam int NUM_IN = 2;
  localparam int IDX_HF = 0;
  localparam int IDX_LF = 1;

  logic [1:0]        rst_pipe_q;
  logic              rst_s_n;
  logic              clr;
  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] rise;
  logic              hf_ev;
  logic              gate_open;
  logic              inc;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  assign clr            = ~run_en_i;
  assign raw_in[IDX_HF] = hf_i;
  assign raw_in[IDX_LF] = lf_i;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
    gmc_edge_sync u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_s_n),
      .clr_i  (clr),
      .async_i(raw_in[g]),
      .rise_o (rise[g])
    );
  end

  if (HF_DIV > 1) begin : g_div
    gmc_prescaler #(.DIV(HF_DIV)) u_div (
      .clk_i (clk_i),
      .rst_ni(rst_s_n),
      .clr_i (clr),
      .ev_i  (rise[IDX_HF]),
      .ev_o  (hf_ev)
    );
  end else begin : g_nodiv
    assign hf_ev = rise[IDX_HF];
  end

  gmc_gate_ctrl #(
    .GATE_SHORT(GATE_SHORT),
    .GATE_LONG (GATE_LONG)
  ) u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_s_n),
    .clr_i        (clr),
    .period_mode_i(period_mode_i),
    .gate_long_i  (gate_long_i),
    .tick_i       (tick_i),
    .lf_rise_i    (rise[IDX_LF]),
    .open_o       (gate_open),
    .done_o       (done_o),
    .done_evt_o   (done_evt_o)
  );

  always_comb begin
    if (!gate_open)         inc = 1'b0;
    else if (period_mode_i) inc = tick_i;
    else if (sel_low_i)     inc = rise[IDX_LF];
    else                    inc = hf_ev;
  end

  gmc_sat_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_s_n),
    .clr_i  (clr),
    .inc_i  (inc),
    .count_o(count_o)
  );
endmodule

// File: rtl/gmc_checker.sv
module gmc_checker #(
  parameter int CNT_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_en_i,
  input logic [CNT_W-1:0] count_o,
  input logic             done_o,
  input logic             done_evt_o
);
  p_clear_when_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_i |=> (count_o == '0) && !done_o && !done_evt_o);

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_en_i && (&count_o) |=> (&count_o));

  p_single_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_en_i && $past(run_en_i) |->
      (count_o == $past(count_o)) || (count_o == CNT_W'($past(count_o) + 1'b1)));

  p_hold_result_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_en_i && done_o |=> $stable(count_o) && done_o);

  p_evt_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_evt_o |-> done_o && !$past(done_o));

  p_evt_on_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> done_evt_o);

  p_evt_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_evt_o |=> !done_evt_o);
endmodule

bind gated_meas_counter gmc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_en_i  (run_en_i),
  .count_o   (count_o),
  .done_o    (done_o),
  .done_evt_o(done_evt_o)
);

// File: tb/gated_meas_counter_tb_top.sv
module gated_meas_counter_tb_top;
  localparam int W  = 20;
  localparam int SW = 8;
  localparam int GS = 60;
  localparam int GL = 120;

  logic        clk = 1'b0;
  logic        rst_n, run_en, sel_low, pmode, glong, hf, lf;
  logic [31:0] cyc = '0;
  int unsigned tick_total = 0;
  logic        tick;

  logic [W-1:0]  cnt_big;
  logic [SW-1:0] cnt_small;
  logic          done_big, evt_big, done_small, evt_small;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tick = (cyc[3:0] == 4'd0);
  always @(posedge clk) tick_total <= tick_total + (tick ? 1 : 0);

  gated_meas_counter #(.CNT_W(W), .GATE_SHORT(GS), .GATE_LONG(GL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_en_i(run_en), .sel_low_i(sel_low),
    .period_mode_i(pmode), .gate_long_i(glong), .tick_i(tick),
    .hf_i(hf), .lf_i(lf), .count_o(cnt_big), .done_o(done_big), .done_evt_o(evt_big));

  gated_meas_counter #(.CNT_W(SW), .GATE_SHORT(GS), .GATE_LONG(GL)) dut_small (
    .clk_i(clk), .rst_ni(rst_n), .run_en_i(run_en), .sel_low_i(sel_low),
    .period_mode_i(pmode), .gate_long_i(glong), .tick_i(tick),
    .hf_i(hf), .lf_i(lf), .count_o(cnt_small), .done_o(done_small), .done_evt_o(evt_small));

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input bit on_lf, input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      if (on_lf) lf = 1'b1; else hf = 1'b1;
      step(hi);
      if (on_lf) lf = 1'b0; else hf = 1'b0;
      step(lo);
    end
  endtask

  function automatic longint exp_freq(input bit sl, input int k);
    return sl ? longint'(k) : longint'(k / 8);
  endfunction

  function automatic longint sat_to(input longint v, input int w);
    longint mx = (longint'(1) << w) - 1;
    return (v > mx) ? mx : v;
  endfunction

  task automatic wait_tick_edge();
    do step(1); while (!tick);
  endtask

  task automatic freq_test(input bit sl, input bit lng, input int k);
    int unsigned t0;
    int guard;
    longint expv;
    longint held;
    run_en = 1'b0; sel_low = sl; pmode = 1'b0; glong = lng; hf = 1'b0; lf = 1'b0;
    step(2);
    run_en = 1'b1;
    wait_tick_edge();
    t0 = tick_total;
    step(8);
    pulses(sl, k, 2, 2);
    check(done_big == 1'b0, "R4 done early", done_big, 0);
    guard = 0;
    while (!done_big && guard < 4000) begin step(1); guard++; end
    check(tick_total - t0 == (lng ? GL : GS) + 1, "R4 gate ticks",
          tick_total - t0, (lng ? GL : GS) + 1);
    check(evt_big == 1'b1, "R8 event with done", evt_big, 1);
    expv = exp_freq(sl, k);
    check(cnt_big == expv, sl ? "R2 lf count" : "R3 hf count /8", cnt_big, expv);
    check(cnt_small == sat_to(expv, SW), "R6 narrow count saturates", cnt_small, sat_to(expv, SW));
    step(1);
    check(evt_big == 1'b0, "R8 event one cycle", evt_big, 0);
    held = cnt_big;
    pulses(1'b1, 3, 2, 2);
    pulses(1'b0, 9, 2, 2);
    check(cnt_big == held && done_big, "R7 result held", cnt_big, held);
    run_en = 1'b0;
    step(1);
    check(cnt_big == 0 && !done_big && !evt_big, "R1 clear on disable", cnt_big, 0);
  endtask

  task automatic period_test(input bit lng, input int p, input bit sl);
    int e;
    e = lng ? 2 : 1;
    run_en = 1'b0; sel_low = sl; pmode = 1'b1; glong = lng; hf = 1'b0; lf = 1'b0;
    step(2);
    run_en = 1'b1;
    wait_tick_edge();
    step(8);
    for (int i = 0; i <= e; i++) begin
      if (i == e) check(done_big == 1'b0, "R5 done before closing edge", done_big, 0);
      lf = 1'b1;
      step(4);
      lf = 1'b0;
      if (i < e) step(16 * p - 4);
    end
    step(6);
    check(done_big == 1'b1, "R5 done after closing edge", done_big, 1);
    check(cnt_big == p * e, "R5 period ticks", cnt_big, p * e);
    run_en = 1'b0;
    step(1);
  endtask

  initial begin
    int k;
    rst_n = 1'b0; run_en = 1'b0; sel_low = 1'b0; pmode = 1'b0; glong = 1'b0;
    hf = 1'b0; lf = 1'b0;
    void'($urandom(32'h5eed_0042));
    step(3);
    rst_n = 1'b1;
    step(4);
    check(cnt_big == 0 && !done_big && !evt_big, "R1 reset state", cnt_big, 0);

    pulses(1'b1, 10, 2, 2);
    pulses(1'b0, 20, 2, 2);
    check(cnt_big == 0 && !done_big, "R1 inputs ignored while disabled", cnt_big, 0);

    freq_test(1'b0, 1'b0, 7);
    freq_test(1'b0, 1'b0, 8);
    freq_test(1'b1, 1'b0, 0);
    freq_test(1'b1, 1'b1, 300);
    freq_test(1'b0, 1'b1, 100);

    period_test(1'b0, 1, 1'b0);
    period_test(1'b1, 3, 1'b1);

    for (int r = 0; r < 10; r++) begin
      k = int'($urandom_range(100, 0));
      freq_test(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), k);
    end
    for (int r = 0; r < 6; r++) begin
      period_test(1'($urandom_range(1, 0)), int'($urandom_range(20, 1)),
                  1'($urandom_range(1, 0)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 32'd190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected finish", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule